// File: doc/BRIEF.md
# Pipelined Wishbone Cache-Line Refill Master

This block sits beside a data cache and owns the bus side of miss handling. When the cache reports a read miss it hands over the miss address, the set index the line will occupy and the way chosen for replacement. The block then fetches the whole line over a pipelined Wishbone bus. It issues one read strobe per row and keeps issuing while the slave accepts. Every acknowledged word goes straight to the cache data RAM write port, tagged with the way and the row. The row the requester asked for is kept aside as the load result. Once the last row lands, the line is marked valid and a one-cycle done pulse is raised.

Two independent trackers run during a refill. The first is an issue address, which moves forward only on an accepted strobe. The second is a store-row counter, which moves forward only on an acknowledge. Because of this split, the slave may stall and acknowledge in any interleaving. The last accepted strobe and the last acknowledge may also coincide on one clock.

The same bus port also carries single-beat stores and uncached loads. When no refill is running, store hits from the cache pipeline pass through to the data RAM port.

Top module: `line_refill_master`

## Requirements
- R1: Reset is synchronous and active low. In the cycle after reset, every bit of `line_valid` is 0 and `wb_cyc`, `wb_stb`, `busy` and `done` are all low.
- R2: A refill is requested with `miss_kind` = 0. From the first refill cycle until completion, `wb_cyc` stays high, `wb_we` stays low and `wb_sel` is all ones.
- R3: The first strobe of a refill carries the miss address with every bit below the line boundary cleared, which is row 0 of the line. The address then steps by one row (DATA_W/8 bytes) only after a cycle with `wb_stb` high and `wb_stall` low. `wb_stb` stays high until exactly LINE_ROWS strobes have been accepted, and it drops right after the last one.
- R4: Every acknowledge during a refill drives `ram_we` in that same cycle with `ram_way` = the miss way, `ram_sel` all ones, `ram_data` = `wb_dat_i` and `ram_row` = index·LINE_ROWS + k, where k counts acknowledges from 0. Only the in-line row bits increment, so the index part never changes.
- R5: The acknowledged word whose row equals the row of the miss address is presented on `done_data` when `done` is high.
- R6: A refill completes on an acknowledge that arrives once all strobes are sent while the store-row counter points at the last row. In the next cycle, `done` is high for exactly one cycle, `wb_cyc`, `wb_stb` and `busy` are low, and the `line_valid` bit at position index·WAYS + way is set.
- R7: With a slave that acknowledges in the same cycle it accepts, the final strobe and the final acknowledge land on one clock, and the refill still completes as in R6 with every row written.
- R8: A store (`miss_kind` = 1) puts `miss_addr`, `miss_sel` and `miss_wdata` on the bus with `wb_we` high. The strobe falls after the first accepted cycle, and an acknowledge ends the cycle with a `done` pulse one clock later.
- R9: An uncached load (`miss_kind` = 2) drives `wb_we` low and `wb_sel` all ones, and returns the acknowledged word on `done_data` with the `done` pulse.
- R10: `miss_valid` is ignored while `busy` is high. A refill in flight keeps its addresses, its read direction and its row sequence.
- R11: Outside a refill acknowledge, the RAM port passes through `hit_wr_en`, `hit_wr_way`, `hit_wr_row`, `hit_wr_data` and `hit_wr_sel`. A store hit must never be raised while a refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Request strobe, taken only when idle |
| miss_kind | input | 2 | 0 line refill, 1 store, 2 uncached load |
| miss_addr | input | ADR_W | Byte address of the access |
| miss_index | input | IDX_BITS | Set the refilled line goes to |
| miss_way | input | WAY_BITS | Way the refilled line goes to |
| miss_wdata | input | DATA_W | Store data |
| miss_sel | input | SEL_W | Store byte enables |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Load result, valid with done |
| line_valid | output | SETS*WAYS | Valid bit per line, bit index·WAYS+way |
| hit_wr_en | input | 1 | Store-hit write request from the pipeline |
| hit_wr_way | input | WAY_BITS | Store-hit way |
| hit_wr_row | input | ROW_BITS | Store-hit RAM row |
| hit_wr_data | input | DATA_W | Store-hit data |
| hit_wr_sel | input | SEL_W | Store-hit byte enables |
| ram_we | output | 1 | Data RAM write enable |
| ram_way | output | WAY_BITS | Data RAM way |
| ram_row | output | ROW_BITS | Data RAM row |
| ram_data | output | DATA_W | Data RAM write data |
| ram_sel | output | SEL_W | Data RAM byte enables |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | ADR_W | Bus byte address |
| wb_sel | output | SEL_W | Bus byte selects |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |
| wb_stall | input | 1 | Bus stall |

## Verification
The bench builds the block with LINE_ROWS = 4, SETS = 8 and WAYS = 4, keeping DATA_W = 64 and ADR_W = 64. Short lines mean the last-row detection, the in-line row wrap and the request-row capture all run on every refill, including when the requested row is row 0 or the last row. Four ways and eight sets give distinct bit positions in `line_valid` and visibly different index bits in `ram_row`. A slave that can either acknowledge in the same cycle or after a queue, under random stall, covers both the coinciding final strobe and acknowledge and the case where acknowledges lag far behind issue.

// File: rtl/lrm_pkg.sv
// Shared types for the line refill master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package lrm_pkg;

    // Controller state: idle, multi-beat line refill, single-beat transfer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REFILL = 2'd1,
        ST_SINGLE = 2'd2
    } lrm_state_e;

    // Request kind as encoded on the miss_kind port.
    typedef enum logic [1:0] {
        KIND_REFILL = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_NCLOAD = 2'd2
    } lrm_kind_e;

endpackage

// File: rtl/lrm_issue.sv
// Request issue tracker: owns wb_adr and wb_stb.
// In refill mode the address steps through the rows of one line, one row
// per accepted strobe. The strobe drops as the last row is accepted. In
// single mode the strobe drops after the first accepted cycle.
// Assumes ADR_W > ROW_OFF + ROW_LINE_BITS and ROW_LINE_BITS >= 1.
module lrm_issue #(
    parameter int ADR_W         = 64,
    parameter int ROW_OFF       = 3,
    parameter int ROW_LINE_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_line,
    input  logic             load_single,
    input  logic [ADR_W-1:0] line_adr,
    input  logic [ADR_W-1:0] single_adr,
    input  logic             refill_mode,
    input  logic             single_mode,
    input  logic             finish,
    input  logic             stall,
    output logic [ADR_W-1:0] adr,
    output logic             stb,
    output logic             sent_all
);
    localparam int LINE_OFF = ROW_OFF + ROW_LINE_BITS;

    logic [ADR_W-1:0]         adr_q;
    logic                     stb_q;
    logic [ADR_W-1:0]         adr_next;
    logic [ROW_LINE_BITS-1:0] adr_row;
    logic                     taken;
    logic                     at_last;

    assign adr_row = adr_q[LINE_OFF-1:ROW_OFF];
    assign taken   = stb_q && !stall;
    assign at_last = &adr_row;

    // All requests are out when the strobe is low, or when the last row is accepted now.
    assign sent_all = !stb_q || (refill_mode && taken && at_last);

    // Next row address: narrow increment inside the line, upper bits kept.
    always_comb begin
        adr_next                      = adr_q;
        adr_next[LINE_OFF-1:ROW_OFF]  = adr_row + 1'b1;
    end

    // Strobe and address register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
            stb_q <= 1'b0;
        end else if (load_line) begin
            adr_q <= line_adr;
            stb_q <= 1'b1;
        end else if (load_single) begin
            adr_q <= single_adr;
            stb_q <= 1'b1;
        end else if (finish) begin
            stb_q <= 1'b0;
        end else if (refill_mode && taken) begin
            adr_q <= adr_next;
            if (at_last) begin
                stb_q <= 1'b0;
            end
        end else if (single_mode && taken) begin
            stb_q <= 1'b0;
        end
    end

    assign adr = adr_q;
    assign stb = stb_q;

endmodule

// File: rtl/lrm_collect.sv
// Acknowledge collector: holds the data RAM row that the next returning
// word is written to. It loads {index, 0} at refill start and advances by
// one in-line row per acknowledge, leaving the index bits untouched.
// Assumes ROW_LINE_BITS >= 1 and IDX_BITS >= 1.
module lrm_collect #(
    parameter int IDX_BITS      = 5,
    parameter int ROW_LINE_BITS = 3,
    localparam int ROW_BITS     = IDX_BITS + ROW_LINE_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [IDX_BITS-1:0]      index,
    input  logic                     step,
    output logic [ROW_BITS-1:0]      row,
    output logic [ROW_LINE_BITS-1:0] row_in_line,
    output logic                     last_row
);
    logic [ROW_BITS-1:0] row_q;

    // Store-row counter; only the in-line bits take part in the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (load) begin
            row_q <= {index, {ROW_LINE_BITS{1'b0}}};
        end else if (step) begin
            row_q[ROW_LINE_BITS-1:0] <= row_q[ROW_LINE_BITS-1:0] + 1'b1;
        end
    end

    assign row         = row_q;
    assign row_in_line = row_q[ROW_LINE_BITS-1:0];
    assign last_row    = &row_q[ROW_LINE_BITS-1:0];

endmodule

// File: rtl/lrm_valid.sv
// Line valid bits, one per set and way. Reset clears them all, so every
// access misses. A completed refill sets exactly one bit.
// Assumes SETS*WAYS is small enough for flops (no RAM inference).
module lrm_valid #(
    parameter int SETS      = 32,
    parameter int WAYS      = 2,
    localparam int IDX_BITS = $clog2(SETS),
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_BITS-1:0]  set_idx,
    input  logic [WAY_BITS-1:0]  set_way,
    output logic [SETS*WAYS-1:0] valid
);
    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            // One valid flop, set on refill completion for its own set and way.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[s*WAYS+w] <= 1'b0;
                end else if (set_en && set_idx == IDX_BITS'(s) && set_way == WAY_BITS'(w)) begin
                    valid[s*WAYS+w] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/line_refill_master.sv
// Pipelined Wishbone line refill master.
// It accepts a refill, store or uncached-load request while idle. For a
// refill it issues LINE_ROWS pipelined reads and writes each acknowledged
// word into the data RAM. It keeps the requested row as the result, sets
// the line valid bit and pulses done. Store hits pass through to the RAM
// port when no refill acknowledge is being written.
// Assumes WAYS >= 2, SETS >= 2, LINE_ROWS >= 2 (all powers of two),
// DATA_W a power-of-two multiple of 8, and a slave that never acknowledges
// more requests than were accepted.
module line_refill_master
    import lrm_pkg::*;
#(
    parameter int DATA_W         = 64,
    parameter int ADR_W          = 64,
    parameter int LINE_ROWS      = 8,
    parameter int SETS           = 32,
    parameter int WAYS           = 2,
    localparam int SEL_W         = DATA_W / 8,
    localparam int ROW_OFF       = $clog2(SEL_W),
    localparam int ROW_LINE_BITS = $clog2(LINE_ROWS),
    localparam int LINE_OFF      = ROW_OFF + ROW_LINE_BITS,
    localparam int IDX_BITS      = $clog2(SETS),
    localparam int WAY_BITS      = $clog2(WAYS),
    localparam int ROW_BITS      = IDX_BITS + ROW_LINE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [1:0]           miss_kind,
    input  logic [ADR_W-1:0]     miss_addr,
    input  logic [IDX_BITS-1:0]  miss_index,
    input  logic [WAY_BITS-1:0]  miss_way,
    input  logic [DATA_W-1:0]    miss_wdata,
    input  logic [SEL_W-1:0]     miss_sel,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    done_data,
    output logic [SETS*WAYS-1:0] line_valid,
    input  logic                 hit_wr_en,
    input  logic [WAY_BITS-1:0]  hit_wr_way,
    input  logic [ROW_BITS-1:0]  hit_wr_row,
    input  logic [DATA_W-1:0]    hit_wr_data,
    input  logic [SEL_W-1:0]     hit_wr_sel,
    output logic                 ram_we,
    output logic [WAY_BITS-1:0]  ram_way,
    output logic [ROW_BITS-1:0]  ram_row,
    output logic [DATA_W-1:0]    ram_data,
    output logic [SEL_W-1:0]     ram_sel,
    output logic                 wb_cyc,
    output logic                 wb_stb,
    output logic                 wb_we,
    output logic [ADR_W-1:0]     wb_adr,
    output logic [SEL_W-1:0]     wb_sel,
    output logic [DATA_W-1:0]    wb_dat_o,
    input  logic [DATA_W-1:0]    wb_dat_i,
    input  logic                 wb_ack,
    input  logic                 wb_stall
);
    lrm_state_e               state_q;
    lrm_kind_e                kind;
    logic                     idle, refilling, single_mode;
    logic                     start_line, start_single;
    logic [ADR_W-1:0]         line_adr;
    logic                     sent_all;
    logic                     refill_ack, refill_done, single_done;
    logic [ROW_BITS-1:0]      store_row;
    logic [ROW_LINE_BITS-1:0] store_row_in_line;
    logic                     store_last;
    logic [ROW_LINE_BITS-1:0] want_row_q;
    logic [WAY_BITS-1:0]      way_q;
    logic                     is_nc_q;
    logic                     cyc_q, we_q, done_q;
    logic [SEL_W-1:0]         sel_q;
    logic [DATA_W-1:0]        dat_o_q, result_q;

    assign kind         = lrm_kind_e'(miss_kind);
    assign idle         = (state_q == ST_IDLE);
    assign refilling    = (state_q == ST_REFILL);
    assign single_mode  = (state_q == ST_SINGLE);
    assign start_line   = idle && miss_valid && kind == KIND_REFILL;
    assign start_single = idle && miss_valid && (kind == KIND_STORE || kind == KIND_NCLOAD);
    assign line_adr     = {miss_addr[ADR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
    assign refill_ack   = refilling && wb_ack;
    assign refill_done  = refill_ack && sent_all && store_last;
    assign single_done  = single_mode && wb_ack;

    lrm_issue #(
        .ADR_W        (ADR_W),
        .ROW_OFF      (ROW_OFF),
        .ROW_LINE_BITS(ROW_LINE_BITS)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_line  (start_line),
        .load_single(start_single),
        .line_adr   (line_adr),
        .single_adr (miss_addr),
        .refill_mode(refilling),
        .single_mode(single_mode),
        .finish     (refill_done || single_done),
        .stall      (wb_stall),
        .adr        (wb_adr),
        .stb        (wb_stb),
        .sent_all   (sent_all)
    );

    lrm_collect #(
        .IDX_BITS     (IDX_BITS),
        .ROW_LINE_BITS(ROW_LINE_BITS)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_line),
        .index      (miss_index),
        .step       (refill_ack),
        .row        (store_row),
        .row_in_line(store_row_in_line),
        .last_row   (store_last)
    );

    lrm_valid #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_valid (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (refill_done),
        .set_idx(store_row[ROW_BITS-1:ROW_LINE_BITS]),
        .set_way(way_q),
        .valid  (line_valid)
    );

    // Transfer control: state, bus qualifiers, result capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cyc_q      <= 1'b0;
            we_q       <= 1'b0;
            sel_q      <= '0;
            dat_o_q    <= '0;
            way_q      <= '0;
            want_row_q <= '0;
            is_nc_q    <= 1'b0;
            result_q   <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_line) begin
                        state_q    <= ST_REFILL;
                        cyc_q      <= 1'b1;
                        we_q       <= 1'b0;
                        sel_q      <= '1;
                        way_q      <= miss_way;
                        want_row_q <= miss_addr[LINE_OFF-1:ROW_OFF];
                    end else if (start_single) begin
                        state_q <= ST_SINGLE;
                        cyc_q   <= 1'b1;
                        is_nc_q <= (kind == KIND_NCLOAD);
                        we_q    <= (kind == KIND_STORE);
                        sel_q   <= (kind == KIND_STORE) ? miss_sel : '1;
                        dat_o_q <= miss_wdata;
                    end
                end
                ST_REFILL: begin
                    if (refill_ack && store_row_in_line == want_row_q) begin
                        result_q <= wb_dat_i;
                    end
                    if (refill_done) begin
                        state_q <= ST_IDLE;
                        cyc_q   <= 1'b0;
                        done_q  <= 1'b1;
                    end
                end
                ST_SINGLE: begin
                    if (single_done) begin
                        state_q <= ST_IDLE;
                        cyc_q   <= 1'b0;
                        we_q    <= 1'b0;
                        done_q  <= 1'b1;
                        if (is_nc_q) begin
                            result_q <= wb_dat_i;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data RAM write port: refill words take the port, otherwise store hits pass through.
    always_comb begin
        if (refill_ack) begin
            ram_we   = 1'b1;
            ram_way  = way_q;
            ram_row  = store_row;
            ram_data = wb_dat_i;
            ram_sel  = '1;
        end else begin
            ram_we   = hit_wr_en;
            ram_way  = hit_wr_way;
            ram_row  = hit_wr_row;
            ram_data = hit_wr_data;
            ram_sel  = hit_wr_sel;
        end
    end

    assign busy      = !idle;
    assign done      = done_q;
    assign done_data = result_q;
    assign wb_cyc    = cyc_q;
    assign wb_we     = we_q;
    assign wb_sel    = sel_q;
    assign wb_dat_o  = dat_o_q;

endmodule

// File: rtl/lrm_checker.sv
// Protocol and safety checks for line_refill_master, bound to every instance.
// Assumes rst_n is the synchronous active-low reset of the bound block.
module lrm_checker #(
    parameter int ADR_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refilling,
    input logic             hit_wr_en,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_we,
    input logic             wb_stall,
    input logic             wb_ack,
    input logic [ADR_W-1:0] wb_adr,
    input logic             done,
    input logic             ram_we
);
    // R3: a strobe is only raised inside a bus cycle.
    p_stb_in_cyc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    // R3: a stalled refill strobe keeps its address.
    p_adr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refilling && wb_stb && wb_stall) |=> $stable(wb_adr));

    // R2: a refill holds the cycle open and only reads.
    p_refill_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        refilling |-> (wb_cyc && !wb_we));

    // R4: every refill acknowledge writes the data RAM.
    p_ack_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refilling && wb_ack) |-> ram_we);

    // R6: done lasts one cycle and comes with the bus released.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wb_cyc && !wb_stb));

    // R11: no store hit may reach the RAM while a refill is in progress.
    p_no_hit_refill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        refilling |-> !hit_wr_en);

endmodule

bind line_refill_master lrm_checker #(.ADR_W(ADR_W)) u_lrm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .refilling(refilling),
    .hit_wr_en(hit_wr_en),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_stall (wb_stall),
    .wb_ack   (wb_ack),
    .wb_adr   (wb_adr),
    .done     (done),
    .ram_we   (ram_we)
);

// File: tb/tb_line_refill_master.sv
// Bench for line_refill_master. A behavioural slave (queue of accepted
// addresses, random stall, optional same-cycle acknowledge) and a
// per-clock reference model (issue count, ack count) are compared each cycle.
module tb_line_refill_master;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 64;
    localparam int ADR_W      = 64;
    localparam int LINE_ROWS  = 4;
    localparam int SETS       = 8;
    localparam int WAYS       = 4;
    localparam int SEL_W      = DATA_W / 8;
    localparam int RB         = SEL_W;
    localparam int IDX_BITS   = $clog2(SETS);
    localparam int WAY_BITS   = $clog2(WAYS);
    localparam int ROW_BITS   = IDX_BITS + $clog2(LINE_ROWS);
    localparam int LINE_BYTES = LINE_ROWS * RB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [1:0] miss_kind = 2'd0;
    logic [ADR_W-1:0] miss_addr = '0;
    logic [IDX_BITS-1:0] miss_index = '0;
    logic [WAY_BITS-1:0] miss_way = '0;
    logic [DATA_W-1:0] miss_wdata = '0;
    logic [SEL_W-1:0] miss_sel = '0;
    logic busy, done;
    logic [DATA_W-1:0] done_data;
    logic [SETS*WAYS-1:0] line_valid;
    logic hit_wr_en = 1'b0;
    logic [WAY_BITS-1:0] hit_wr_way = '0;
    logic [ROW_BITS-1:0] hit_wr_row = '0;
    logic [DATA_W-1:0] hit_wr_data = '0;
    logic [SEL_W-1:0] hit_wr_sel = '0;
    logic ram_we;
    logic [WAY_BITS-1:0] ram_way;
    logic [ROW_BITS-1:0] ram_row;
    logic [DATA_W-1:0] ram_data;
    logic [SEL_W-1:0] ram_sel;
    logic wb_cyc, wb_stb, wb_we;
    logic [ADR_W-1:0] wb_adr;
    logic [SEL_W-1:0] wb_sel;
    logic [DATA_W-1:0] wb_dat_o, wb_dat_i;
    logic wb_ack, wb_stall;

    logic zero_lat = 1'b0;
    logic stall_r = 1'b0;
    logic ack_r = 1'b0;
    logic [DATA_W-1:0] dat_r = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] fdat(input logic [ADR_W-1:0] a);
        return {~a[31:0], a[31:0]};
    endfunction

    // Slave: same-cycle acknowledge in zero-latency mode, else queued replies.
    assign wb_stall = stall_r;
    assign wb_ack   = zero_lat ? (wb_cyc && wb_stb && !stall_r) : ack_r;
    assign wb_dat_i = zero_lat ? fdat(wb_adr) : dat_r;

    line_refill_master #(
        .DATA_W(DATA_W), .ADR_W(ADR_W), .LINE_ROWS(LINE_ROWS), .SETS(SETS), .WAYS(WAYS)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_kind(miss_kind), .miss_addr(miss_addr),
        .miss_index(miss_index), .miss_way(miss_way), .miss_wdata(miss_wdata), .miss_sel(miss_sel),
        .busy(busy), .done(done), .done_data(done_data), .line_valid(line_valid),
        .hit_wr_en(hit_wr_en), .hit_wr_way(hit_wr_way), .hit_wr_row(hit_wr_row),
        .hit_wr_data(hit_wr_data), .hit_wr_sel(hit_wr_sel),
        .ram_we(ram_we), .ram_way(ram_way), .ram_row(ram_row), .ram_data(ram_data), .ram_sel(ram_sel),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr), .wb_sel(wb_sel),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_stall(wb_stall)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        miss_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen at the ports
        check(line_valid == '0, "R1 line_valid cleared", 64'(line_valid), 64'd0);
        check(!wb_cyc && !wb_stb, "R1 bus idle", {62'd0, wb_cyc, wb_stb}, 64'd0);
        check(!busy && !done, "R1 busy/done low", {62'd0, busy, done}, 64'd0);
    endtask

    // Slave step for one cycle: random stall, queued acknowledge.
    task automatic slave_step(input int stall_pct, ref logic [ADR_W-1:0] pend[$]);
        stall_r = ($urandom_range(0, 99) < stall_pct);
        ack_r = 1'b0;
        if (!zero_lat && pend.size() > 0 && $urandom_range(0, 2) != 0) begin
            ack_r = 1'b1;
            dat_r = fdat(pend.pop_front());
        end
    endtask

    task automatic refill(input logic [ADR_W-1:0] addr, input int idx, input int way,
                          input bit zl, input int stall_pct, input bit poke);
        logic [ADR_W-1:0] base;
        logic [ADR_W-1:0] pend[$];
        int want, n_iss, n_ack, cnt;
        bit last_prev, fin;
        base = addr & ~ADR_W'(LINE_BYTES - 1);
        want = int'((addr >> $clog2(RB)) % LINE_ROWS);
        n_iss = 0; n_ack = 0; cnt = 0; last_prev = 0; fin = 0;
        @(negedge clk);
        zero_lat = zl; stall_r = 1'b0; ack_r = 1'b0;
        miss_valid = 1'b1; miss_kind = 2'd0; miss_addr = addr;
        miss_index = IDX_BITS'(idx); miss_way = WAY_BITS'(way);
        while (!fin && cnt < 2000) begin
            @(negedge clk);
            cnt++;
            miss_valid = poke && cnt <= 3;
            miss_kind  = poke ? 2'd1 : 2'd0;
            slave_step(stall_pct, pend);
            #1;
            check(done == last_prev, zl ? "R7 done after final ack" : "R6 done after final ack",
                  64'(done), 64'(last_prev));
            if (done) begin
                check(done_data == fdat(base + ADR_W'(want * RB)), "R5 requested row result",
                      done_data, fdat(base + ADR_W'(want * RB)));
                check(!wb_cyc && !wb_stb && !busy, "R6 released at completion",
                      {61'd0, wb_cyc, wb_stb, busy}, 64'd0);
                check(line_valid[idx*WAYS+way], "R6 line valid set", 64'(line_valid), 64'd1);
                fin = 1;
            end else begin
                check(wb_cyc && !wb_we && wb_sel == '1, "R2 read cycle held",
                      {wb_cyc, wb_we, 62'(wb_sel)}, 64'd0);
                if (poke && cnt <= 3)
                    check(busy && !wb_we, "R10 request ignored while busy", 64'(wb_we), 64'd0);
                check(wb_stb == (n_iss < LINE_ROWS), "R3 strobe count", 64'(wb_stb), 64'(n_iss));
                if (wb_stb)
                    check(wb_adr == base + ADR_W'(n_iss * RB), "R3 row address",
                          wb_adr, base + ADR_W'(n_iss * RB));
                if (wb_ack) begin
                    check(ram_we && ram_way == WAY_BITS'(way) && ram_sel == '1 &&
                          ram_row == ROW_BITS'(idx * LINE_ROWS + n_ack),
                          zl ? "R7 ram write row" : "R4 ram write row",
                          64'(ram_row), 64'(idx * LINE_ROWS + n_ack));
                    check(ram_data == fdat(base + ADR_W'(n_ack * RB)), "R4 ram write data",
                          ram_data, fdat(base + ADR_W'(n_ack * RB)));
                    n_ack++;
                end else begin
                    check(!ram_we, "R4 no write without ack", 64'(ram_we), 64'd0);
                end
                last_prev = wb_ack && n_ack == LINE_ROWS;
                if (wb_cyc && wb_stb && !stall_r) begin
                    if (!zl) pend.push_back(wb_adr);
                    n_iss++;
                end
            end
        end
        if (!fin) check(1'b0, "R6 refill watchdog", 64'(n_ack), 64'(LINE_ROWS));
        miss_valid = 1'b0; miss_kind = 2'd0;
    endtask

    task automatic single(input bit is_store, input logic [ADR_W-1:0] addr,
                          input logic [DATA_W-1:0] wdata, input logic [SEL_W-1:0] sel,
                          input bit zl, input int stall_pct);
        logic [ADR_W-1:0] pend[$];
        logic [SEL_W-1:0] exp_sel;
        int n_iss, cnt;
        bit last_prev, fin;
        n_iss = 0; cnt = 0; last_prev = 0; fin = 0;
        exp_sel = is_store ? sel : '1;
        @(negedge clk);
        zero_lat = zl; stall_r = 1'b0; ack_r = 1'b0;
        miss_valid = 1'b1; miss_kind = is_store ? 2'd1 : 2'd2;
        miss_addr = addr; miss_wdata = wdata; miss_sel = sel;
        while (!fin && cnt < 2000) begin
            @(negedge clk);
            cnt++;
            miss_valid = 1'b0;
            slave_step(stall_pct, pend);
            #1;
            check(done == last_prev, "R8 done after ack", 64'(done), 64'(last_prev));
            if (done) begin
                if (!is_store)
                    check(done_data == fdat(addr), "R9 uncached load result", done_data, fdat(addr));
                check(!wb_cyc && !busy, "R8 bus released", {62'd0, wb_cyc, busy}, 64'd0);
                fin = 1;
            end else begin
                check(wb_cyc && wb_we == is_store && wb_sel == exp_sel,
                      is_store ? "R8 store qualifiers" : "R9 load qualifiers",
                      {wb_cyc, wb_we, 62'(wb_sel)}, {1'b1, is_store, 62'(exp_sel)});
                if (wb_stb) begin
                    check(n_iss == 0, "R8 single strobe", 64'(n_iss), 64'd0);
                    check(wb_adr == addr && (!is_store || wb_dat_o == wdata), "R8 address/data",
                          wb_adr, addr);
                end
                if (wb_ack) last_prev = 1;
                if (wb_cyc && wb_stb && !stall_r) begin
                    if (!zl) pend.push_back(wb_adr);
                    n_iss++;
                end
            end
        end
        if (!fin) check(1'b0, "R8 single watchdog", 64'(n_iss), 64'd1);
    endtask

    // Overall watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R11: store hit passes through to the RAM port when idle
        @(negedge clk);
        hit_wr_en = 1'b1; hit_wr_way = 2'd3; hit_wr_row = 5'd19;
        hit_wr_data = 64'hDEAD_BEEF_0123_4567; hit_wr_sel = 8'h0F;
        #1;
        check(ram_we && ram_way == 2'd3 && ram_row == 5'd19 && ram_data == 64'hDEAD_BEEF_0123_4567
              && ram_sel == 8'h0F, "R11 store hit passthrough", ram_data, 64'hDEAD_BEEF_0123_4567);
        @(negedge clk);
        hit_wr_en = 1'b0;

        // Requested row in the middle, queued slave with stall (R3, R4, R5)
        refill(64'h0000_0000_8000_0050, 2, 1, 1'b0, 30, 1'b0);
        // Requested row is the last row, same-cycle acknowledge (R7)
        refill(64'h0000_0001_1234_00B8, 5, 2, 1'b1, 0, 1'b0);
        // Same-cycle acknowledge under stall (R7)
        refill(64'h0000_0000_4000_00E0, 7, 3, 1'b1, 50, 1'b0);
        // Requests arriving while busy are ignored (R10)
        refill(64'h0000_0000_2000_0008, 0, 0, 1'b0, 60, 1'b1);

        single(1'b1, 64'h0000_0000_3000_1238, 64'h1122_3344_5566_7788, 8'hF0, 1'b0, 40);
        single(1'b1, 64'h0000_0000_3000_2000, 64'hCAFE_F00D_0000_0001, 8'h01, 1'b1, 20);
        single(1'b0, 64'h0000_0000_5000_0010, '0, '0, 1'b0, 50);
        single(1'b0, 64'h0000_0000_5000_0FF8, '0, '0, 1'b1, 0);

        for (int i = 0; i < 12; i++) begin
            int idx, way, row;
            idx = $urandom_range(0, SETS - 1);
            way = $urandom_range(0, WAYS - 1);
            row = $urandom_range(0, LINE_ROWS - 1);
            refill({32'd0, $urandom_range(1, 255), 8'(idx * LINE_BYTES + row * RB)} & 64'hFFFF_FFFF,
                   idx, way, 1'($urandom_range(0, 1)), $urandom_range(0, 70), 1'b0);
        end

        // R1: reset after activity clears every valid bit
        do_reset();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule